// File: doc/BRIEF.md
# Store Undo Log with Reverse Replay

This block holds one rollback point for a cache. Before a store overwrites a block, the cache hands the block's address and its old data to the log, which appends them to a FIFO. When a fingerprint comparison succeeds, the pair of cores agrees that execution so far is correct. On that event the log is emptied and a new rollback point begins. In the same cycle, the live architectural registers are copied into a shadow set.

When a mismatch calls for recovery, the log plays its records back newest first on a write-back port toward the cache, one per cycle. This restores every overwritten block to the value it held at the rollback point. The shadow registers are presented for reloading at the same time.

An early-warning output rises while a few entries are still free, so that control logic can force a comparison before the log runs out of space. A store that arrives while the log is completely full is dropped and flagged as an error.

Top module: `ckpt_undo_log`

## Requirements
- R1: An accepted store records its address and old data. That record later appears unchanged on `wb_addr` and `wb_data` during replay.
- R2: When `commit` is accepted without a store, the log becomes empty. A later rollback then produces no write-back and `replay_done` goes high on the cycle after `rollback`.
- R3: A store presented while the log already holds `DEPTH` entries is not recorded. On the next cycle `ovf_err` goes high and stays high until a commit or rollback is accepted.
- R4: During replay, `wb_valid` is high for exactly as many cycles as there are entries. The entries come out in reverse order of insertion, one per cycle, starting on the cycle after `rollback`.
- R5: `force_cmp` is high exactly when the log holds at least `DEPTH - RESERVE` entries.
- R6: `st_stall` is high during the `rollback` cycle and for the whole replay. Stores, commits and further rollbacks presented while it is high are ignored.
- R7: `replay_done` is a single-cycle pulse. It rises on the first replay cycle in which the log is empty, and after it the block accepts stores again.
- R8: When `commit` is accepted, `regs_restore` takes the value of `regs_live` on the next cycle. `regs_load` pulses for one cycle on the cycle after an accepted rollback.
- R9: A store presented together with an accepted commit becomes the only entry of the new log.
- R10: After reset the log is empty. `wb_valid`, `replay_done`, `force_cmp`, `ovf_err`, `regs_load` and `st_stall` are all low, and `regs_restore` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store about to overwrite a cache block |
| st_addr | input | AW | Address of the block being overwritten |
| st_old | input | DW | Block contents before the store |
| st_stall | output | 1 | Stores, commits and rollbacks are refused this cycle |
| commit | input | 1 | Fingerprints matched: start a new rollback point |
| rollback | input | 1 | Fingerprint mismatch: restore the rollback point |
| wb_valid | output | 1 | Replay write-back toward the cache is valid |
| wb_addr | output | AW | Address to restore |
| wb_data | output | DW | Data to restore |
| replay_done | output | 1 | One-cycle pulse when replay has finished |
| force_cmp | output | 1 | Log nearly full, a comparison should be forced |
| ovf_err | output | 1 | A store was dropped because the log was full |
| regs_live | input | NREGS*RW | Current architectural registers |
| regs_restore | output | NREGS*RW | Shadow register copy from the last commit |
| regs_load | output | 1 | Pulse telling the core to reload `regs_restore` |

## Verification
The hardest state to reach is a full log hit by one more store, followed by a rollback while stores keep arriving. The bench must then show that the dropped store is absent and that all 64 older records come back in reverse order. Directed sequences build this by filling the log past the warning level into overflow, then requesting replay while presenting stores and a second rollback that must be ignored. Random traffic with rare commits and rollbacks covers stores that coincide with commits, and rollbacks on an empty log.

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int DEPTH   = 64,
  parameter int RESERVE = 4,
  parameter int NREGS   = 8,
  parameter int RW      = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_old,
  output logic                st_stall,
  input  logic                commit,
  input  logic                rollback,
  output logic                wb_valid,
  output logic [AW-1:0]       wb_addr,
  output logic [DW-1:0]       wb_data,
  output logic                replay_done,
  output logic                force_cmp,
  output logic                ovf_err,
  input  logic [NREGS*RW-1:0] regs_live,
  output logic [NREGS*RW-1:0] regs_restore,
  output logic                regs_load
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] WARN_LVL = CW'(DEPTH - RESERVE);

  logic [AW-1:0] log_addr [DEPTH];
  logic [DW-1:0] log_data [DEPTH];
  logic [CW-1:0] occ;
  logic [CW-1:0] rd_ptr;
  logic          replaying;
  logic          full;
  logic          wr_en;
  logic [IW-1:0] wr_idx;

  assign full        = (occ == FULL_LVL);
  assign rd_ptr      = occ - CW'(1);
  assign st_stall    = replaying | rollback;
  assign wb_valid    = replaying && (occ != '0);
  assign wb_addr     = log_addr[rd_ptr[IW-1:0]];
  assign wb_data     = log_data[rd_ptr[IW-1:0]];
  assign replay_done = replaying && (occ == '0);
  assign force_cmp   = (occ >= WARN_LVL);
  assign wr_en       = !st_stall && st_valid && (commit || !full);
  assign wr_idx      = commit ? '0 : occ[IW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      log_addr[wr_idx] <= st_addr;
      log_data[wr_idx] <= st_old;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ          <= '0;
      replaying    <= 1'b0;
      ovf_err      <= 1'b0;
      regs_load    <= 1'b0;
      regs_restore <= '0;
    end else begin
      regs_load <= rollback && !replaying;
      if (replaying) begin
        if (occ != '0) occ <= occ - CW'(1);
        else           replaying <= 1'b0;
      end else if (rollback) begin
        replaying <= 1'b1;
        ovf_err   <= 1'b0;
      end else if (commit) begin
        regs_restore <= regs_live;
        ovf_err      <= 1'b0;
        occ          <= st_valid ? CW'(1) : '0;
      end else if (st_valid) begin
        if (full) ovf_err <= 1'b1;
        else      occ     <= occ + CW'(1);
      end
    end
  end
endmodule

module ckpt_undo_log_chk #(
  parameter int DEPTH = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [$clog2(DEPTH+1)-1:0]   occ,
  input logic                         st_valid,
  input logic                         st_stall,
  input logic                         commit,
  input logic                         rollback,
  input logic                         wb_valid,
  input logic                         replay_done,
  input logic                         regs_load
);
  localparam int CW = $clog2(DEPTH + 1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_stall && !commit && occ == CW'(DEPTH)) |=> (occ == CW'(DEPTH)));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> (occ == $past(occ) - CW'(1)));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || replay_done) |-> st_stall);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_done |=> !replay_done && !st_stall || rollback);

  p_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !st_valid && !st_stall) |=> (occ == '0));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs_load |-> $past(rollback));
endmodule

bind ckpt_undo_log ckpt_undo_log_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .st_valid(st_valid),
  .st_stall(st_stall), .commit(commit), .rollback(rollback),
  .wb_valid(wb_valid), .replay_done(replay_done), .regs_load(regs_load)
);

// File: tb/tb_ckpt_undo_log.sv
`timescale 1ns/1ps
module tb_ckpt_undo_log;
  localparam int AW = 32, DW = 64, DEPTH = 64, RESERVE = 4, NREGS = 8, RW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, commit = 1'b0, rollback = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_old = '0;
  logic [NREGS*RW-1:0] regs_live = '0;
  logic st_stall, wb_valid, replay_done, force_cmp, ovf_err, regs_load;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [NREGS*RW-1:0] regs_restore;

  always #2 clk = ~clk;

  ckpt_undo_log #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .RESERVE(RESERVE),
                  .NREGS(NREGS), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_old(st_old), .st_stall(st_stall), .commit(commit), .rollback(rollback),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .replay_done(replay_done), .force_cmp(force_cmp), .ovf_err(ovf_err),
    .regs_live(regs_live), .regs_restore(regs_restore), .regs_load(regs_load));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [AW-1:0] ma [DEPTH];
  logic [DW-1:0] md [DEPTH];
  int mn = 0;
  bit m_rep = 0, m_ovf = 0, m_load = 0;
  logic [NREGS*RW-1:0] m_shadow = '0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_force(input int n);
    return n >= DEPTH - RESERVE;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cyc(input bit sv, input bit cm, input bit rb);
    @(negedge clk);
    st_valid = sv; commit = cm; rollback = rb;
    st_addr = $urandom;
    st_old = {$urandom, $urandom};
    for (int i = 0; i < NREGS; i++) regs_live[i*RW +: RW] = {$urandom, $urandom};
    #1;
    chk(st_stall == (m_rep || rb), "R6 st_stall", st_stall, m_rep || rb);
    chk(wb_valid == (m_rep && mn > 0), "R4 wb_valid", wb_valid, m_rep && mn > 0);
    if (m_rep && mn > 0) begin
      chk(wb_addr == ma[mn-1], "R1 R4 wb_addr", wb_addr, ma[mn-1]);
      chk(wb_data == md[mn-1], "R1 R4 R9 wb_data", wb_data, md[mn-1]);
    end
    chk(replay_done == (m_rep && mn == 0), "R7 R2 replay_done", replay_done, m_rep && mn == 0);
    chk(force_cmp == exp_force(mn), "R5 force_cmp", force_cmp, exp_force(mn));
    chk(ovf_err == m_ovf, "R3 ovf_err", ovf_err, m_ovf);
    chk(regs_load == m_load, "R8 regs_load", regs_load, m_load);
    chk(regs_restore == m_shadow, "R8 regs_restore", regs_restore[127:0], m_shadow[127:0]);
    m_load = rb && !m_rep;
    if (m_rep) begin
      if (mn > 0) mn--; else m_rep = 0;
    end else if (rb) begin
      m_rep = 1; m_ovf = 0;
    end else if (cm) begin
      m_shadow = regs_live; m_ovf = 0; mn = 0;
      if (sv) begin ma[0] = st_addr; md[0] = st_old; mn = 1; end
    end else if (sv) begin
      if (mn < DEPTH) begin ma[mn] = st_addr; md[mn] = st_old; mn++; end
      else m_ovf = 1;
    end
  endtask

  task automatic drain();
    cyc(0, 0, 1);
    while (m_rep) cyc(0, 0, 0);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!wb_valid && !replay_done && !force_cmp && !ovf_err && !regs_load && !st_stall,
        "R10 reset outputs", {wb_valid, replay_done, force_cmp, ovf_err, regs_load, st_stall}, 0);
    chk(regs_restore == '0, "R10 reset shadow", regs_restore[127:0], 0);
    @(negedge clk) rst_n = 1'b1;

    repeat (10) cyc(1, 0, 0);
    drain();

    repeat (5) cyc(1, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    #0; chk(mn == 0, "R2 empty after commit", mn, 0);
    cyc(0, 0, 0);

    repeat (3) cyc(1, 0, 0);
    cyc(1, 1, 0);
    drain();

    repeat (DEPTH + 3) cyc(1, 0, 0);
    cyc(1, 0, 1);
    repeat (5) cyc(1, 0, 0);
    cyc(1, 1, 1);
    while (m_rep) cyc(1, 1, 0);
    cyc(1, 0, 0);

    repeat (DEPTH + 1) cyc(1, 0, 0);
    cyc(1, 1, 0);

    for (int k = 0; k < 6000; k++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 55, r >= 96, r == 95);
    end
    drain();

    finish_run();
  end
endmodule